// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block is the command engine of a byte-wide serial nonvolatile memory model. A bit-level receiver in front of it recovers whole bytes from the serial line. It passes each byte here together with the acknowledge bit the master sent after it. The receiver also reports when the master wants a byte returned. The engine decodes the frame in this order: device address, opcode, two address bytes when the opcode needs them, then data. For every slot it decides whether the slave acknowledges, and on read slots it supplies the data byte.

The engine holds the write-enable latch, a two-bit protection level and a write-in-progress flag, and it reports all three in a status byte. It also holds the internal address counter, a 16-entry page buffer and the memory array, which is a register file. An accepted write, status write or fill-all command starts a self-timed internal cycle that lasts a fixed number of clocks. The memory or status change is committed only when that cycle ends.

Top module: `eeprom_cmd_engine`

## Requirements
- R1: A `start` pulse begins a frame. The first byte is acknowledged only if it equals DEV_ADDR (default 0xA0). On a mismatch it gets no acknowledge, and every later slot of that frame also gets none.
- R2: After reset the array holds 0x00. Opcode 0x03 takes two address bytes, most significant first. Each later read slot returns the array byte at the counter and then increments the counter, wrapping from the last location to 0.
- R3: Opcode 0x06 takes no address. It reads from the counter, which points one past the last location accessed by a read or a write.
- R4: The write-enable latch is clear after reset. Opcode 0x96 sets it and opcode 0x91 clears it.
- R5: Opcode 0x6C loads data bytes into the page buffer, starting at the given address. The offset wraps inside the 16-byte page. When a data byte arrives without the master acknowledge, the page is committed, but only if the latch is set and the page is not protected. Otherwise every byte is still acknowledged and the array is unchanged.
- R6: The status byte has write-in-progress at bit 0, the latch at bit 1, the protection level at bits 3:2, and zeros in bits 7:4. Opcode 0x05 returns it on every read slot, and it is acknowledged during an internal cycle too.
- R7: Opcode 0x6E takes one byte whose bits 3:2 set the protection level. It needs the latch and takes an internal cycle. Level 0 protects nothing, level 1 the upper quarter, level 2 the upper half, and level 3 the whole array.
- R8: Opcode 0x67, ended without the master acknowledge while the latch is set, starts an internal cycle that writes 0xFF to every location.
- R9: The internal cycle keeps write-in-progress high for exactly WRITE_CYCLES clocks. It begins on the clock that takes the final byte, and the latch clears as it ends.
- R10: While write-in-progress is set, every opcode except 0x05 gets no acknowledge and ends the frame.
- R11: `sak_valid` pulses on the clock after each byte or read slot, and `tx_data` changes only then.
- R12: An opcode outside the set above gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start of a new frame |
| rx_valid | input | 1 | A byte from the master is present |
| rx_byte | input | 8 | Byte received from the master |
| rx_mak | input | 1 | Master acknowledge after the received byte (0 ends the frame) |
| tx_req | input | 1 | Master requests a byte from the slave |
| tx_mak | input | 1 | Master acknowledge after the returned byte |
| tx_data | output | 8 | Byte returned to the master |
| sak_valid | output | 1 | Slave acknowledge decision is valid |
| sak | output | 1 | Slave acknowledge (1 = acknowledge) |

## Verification
The hardest window to reach is the one inside an internal write cycle. It has to be entered on purpose by ending a page write without the master acknowledge. Within WRITE_CYCLES clocks the stimulus must then show that a read opcode is refused while the status read is still acknowledged and reports both the busy flag and the latch. The bench drives that window right after each page commit of a full-array fill. It also sweeps all four protection levels against a probe write in each quarter of the array, predicting from the level arithmetic which probes must leave memory untouched.

// File: rtl/eeprom_cmd_engine.sv
module eeprom_cmd_engine #(
  parameter int MEM_BYTES = 128,
  parameter int PAGE_BYTES = 16,
  parameter int WRITE_CYCLES = 20,
  parameter logic [7:0] DEV_ADDR = 8'hA0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       rx_mak,
  input  logic       tx_req,
  input  logic       tx_mak,
  output logic [7:0] tx_data,
  output logic       sak_valid,
  output logic       sak
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(WRITE_CYCLES + 1);

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_CRRD  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h6C;
  localparam logic [7:0] OP_WREN  = 8'h96;
  localparam logic [7:0] OP_WRDI  = 8'h91;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h6E;
  localparam logic [7:0] OP_FILL  = 8'h67;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_OP, S_AH, S_AL, S_RD, S_WR, S_SRD, S_SWR
  } state_t;
  typedef enum logic [1:0] {K_PAGE, K_STAT, K_FILL} kind_t;

  state_t            state;
  kind_t             kind;
  logic [7:0]        mem  [MEM_BYTES];
  logic [7:0]        pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask;
  logic [AW-1:0]     ptr;
  logic [7:0]        ahi;
  logic              is_wr;
  logic              wel, wip;
  logic [1:0]        bp, bp_new;
  logic [CW-1:0]     wcnt;
  logic              ptr_prot;
  logic [7:0]        status;

  assign status   = {4'b0000, bp, wel, wip};
  assign ptr_prot = (bp == 2'd3) | ((bp == 2'd2) & ptr[AW-1]) |
                    ((bp == 2'd1) & ptr[AW-1] & ptr[AW-2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      kind      <= K_PAGE;
      pmask     <= '0;
      ptr       <= '0;
      ahi       <= '0;
      is_wr     <= 1'b0;
      wel       <= 1'b0;
      wip       <= 1'b0;
      bp        <= 2'd0;
      bp_new    <= 2'd0;
      wcnt      <= '0;
      tx_data   <= 8'h00;
      sak_valid <= 1'b0;
      sak       <= 1'b0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'h00;
    end else begin
      sak_valid <= 1'b0;

      if (wip) begin
        if (wcnt == '0) begin
          wip <= 1'b0;
          wel <= 1'b0;
          case (kind)
            K_PAGE: for (int i = 0; i < PAGE_BYTES; i++)
                      if (pmask[i]) mem[{ptr[AW-1:PW], PW'(i)}] <= pbuf[i];
            K_FILL: for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
            default: bp <= bp_new;
          endcase
        end else begin
          wcnt <= wcnt - 1'b1;
        end
      end

      if (start) begin
        state <= S_DEV;
      end else if (rx_valid) begin
        sak_valid <= 1'b1;
        sak       <= 1'b0;
        state     <= S_IDLE;
        case (state)
          S_DEV: if (rx_byte == DEV_ADDR) begin
            sak   <= 1'b1;
            state <= S_OP;
          end
          S_OP: if (!wip || rx_byte == OP_RDSR) begin
            case (rx_byte)
              OP_READ:  begin sak <= 1'b1; is_wr <= 1'b0; state <= S_AH; end
              OP_WRITE: begin sak <= 1'b1; is_wr <= 1'b1; state <= S_AH; end
              OP_CRRD:  begin sak <= 1'b1; state <= S_RD; end
              OP_WREN:  begin sak <= 1'b1; wel <= 1'b1; end
              OP_WRDI:  begin sak <= 1'b1; wel <= 1'b0; end
              OP_RDSR:  begin sak <= 1'b1; state <= S_SRD; end
              OP_WRSR:  begin sak <= 1'b1; state <= S_SWR; end
              OP_FILL: begin
                sak <= 1'b1;
                if (!rx_mak && wel) begin
                  wip  <= 1'b1;
                  wcnt <= CW'(WRITE_CYCLES - 1);
                  kind <= K_FILL;
                end
              end
              default: ;
            endcase
          end
          S_AH: begin
            sak   <= 1'b1;
            ahi   <= rx_byte;
            state <= S_AL;
          end
          S_AL: begin
            sak   <= 1'b1;
            ptr   <= AW'({ahi, rx_byte});
            pmask <= '0;
            state <= is_wr ? S_WR : S_RD;
          end
          S_WR: begin
            sak <= 1'b1;
            pbuf[ptr[PW-1:0]]  <= rx_byte;
            pmask[ptr[PW-1:0]] <= 1'b1;
            ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + PW'(1)};
            if (rx_mak) begin
              state <= S_WR;
            end else if (wel && !ptr_prot) begin
              wip  <= 1'b1;
              wcnt <= CW'(WRITE_CYCLES - 1);
              kind <= K_PAGE;
            end
          end
          S_SWR: begin
            sak    <= 1'b1;
            bp_new <= rx_byte[3:2];
            if (!rx_mak && wel) begin
              wip  <= 1'b1;
              wcnt <= CW'(WRITE_CYCLES - 1);
              kind <= K_STAT;
            end
          end
          default: ;
        endcase
      end else if (tx_req) begin
        sak_valid <= 1'b1;
        sak       <= 1'b0;
        state     <= S_IDLE;
        case (state)
          S_RD: begin
            sak     <= 1'b1;
            tx_data <= mem[ptr];
            ptr     <= ptr + 1'b1;
            if (tx_mak) state <= S_RD;
          end
          S_SRD: begin
            sak     <= 1'b1;
            tx_data <= status;
            if (tx_mak) state <= S_SRD;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eeprom_cmd_engine_chk.sv
module eeprom_cmd_engine_chk #(
  parameter int WRITE_CYCLES = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       tx_req,
  input logic       sak_valid,
  input logic       wip,
  input logic       wel,
  input logic [7:0] tx_data
);
  logic [15:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= '0;
    else        busy_len <= wip ? busy_len + 1'b1 : 16'd0;
  end

  p_resp_after_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sak_valid |-> $past(rx_valid || tx_req));

  p_txdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tx_req) |-> $stable(tx_data));

  p_busy_length_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> busy_len == 16'(WRITE_CYCLES));

  p_latch_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);

  p_cycle_needs_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel));

  p_latch_set_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(rx_valid) && !$past(wip));
endmodule

bind eeprom_cmd_engine eeprom_cmd_engine_chk #(.WRITE_CYCLES(WRITE_CYCLES)) chk_i (.*);

// File: tb/eeprom_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module eeprom_cmd_engine_tb_top;
  localparam int NB = 128;
  localparam logic [7:0] DEV = 8'hA0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rx_valid = 1'b0, rx_mak = 1'b0, tx_req = 1'b0, tx_mak = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [7:0] tx_data;
  logic sak_valid, sak;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic last_sv;
  logic [7:0] model [NB];

  always #2 clk = ~clk;

  eeprom_cmd_engine #(.MEM_BYTES(NB), .PAGE_BYTES(16), .WRITE_CYCLES(20), .DEV_ADDR(DEV)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_mak(rx_mak), .tx_req(tx_req), .tx_mak(tx_mak), .tx_data(tx_data),
    .sak_valid(sak_valid), .sak(sak));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic mak, output logic s);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b; rx_mak = mak;
    @(negedge clk); rx_valid = 1'b0;
    last_sv = sak_valid;
    s = sak_valid & sak;
  endtask

  task automatic get(input logic mak, output logic [7:0] d, output logic s);
    @(negedge clk); tx_req = 1'b1; tx_mak = mak;
    @(negedge clk); tx_req = 1'b0;
    last_sv = sak_valid;
    d = tx_data;
    s = sak_valid & sak;
  endtask

  task automatic cmd(input logic [7:0] op, input logic mak, output logic s);
    logic sd;
    frame_start();
    send(DEV, 1'b1, sd);
    send(op, mak, s);
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic s;
    cmd(8'h05, 1'b1, s);
    get(1'b0, st, s);
  endtask

  task automatic wait_idle();
    logic [7:0] st;
    for (int k = 0; k < 60; k++) begin
      rdsr(st);
      if (!st[0]) break;
    end
  endtask

  task automatic wren();
    logic s;
    cmd(8'h96, 1'b0, s);
  endtask

  task automatic write_one(input int a, input logic [7:0] v, output logic s);
    logic s0;
    wren();
    cmd(8'h6C, 1'b1, s0);
    send(8'(a >> 8), 1'b1, s0);
    send(8'(a), 1'b1, s0);
    send(v, 1'b0, s);
    wait_idle();
  endtask

  task automatic read_at(input int a, output logic [7:0] d);
    logic s;
    cmd(8'h03, 1'b1, s);
    send(8'(a >> 8), 1'b1, s);
    send(8'(a), 1'b1, s);
    get(1'b0, d, s);
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) ^ 8'h5A);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic s, s2;
    logic [7:0] d, st;
    for (int i = 0; i < NB; i++) model[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    rdsr(st);
    chk(st == 8'h00, "R4 reset status", st, 0);
    chk(last_sv == 1'b1, "R11 sak_valid after slot", last_sv, 1);

    frame_start();
    send(8'hA2, 1'b1, s);
    chk(s == 1'b0, "R1 wrong device nack", s, 0);
    send(8'h05, 1'b1, s);
    chk(s == 1'b0, "R1 rest of frame ignored", s, 0);
    frame_start();
    send(DEV, 1'b1, s);
    chk(s == 1'b1, "R1 device ack", s, 1);

    cmd(8'h55, 1'b0, s);
    chk(s == 1'b0, "R12 unknown opcode", s, 0);

    wren();
    rdsr(st);
    chk(st == 8'h02, "R4 latch set", st, 2);
    cmd(8'h91, 1'b0, s);
    rdsr(st);
    chk(st == 8'h00, "R4 latch cleared", st, 0);

    cmd(8'h6C, 1'b1, s);
    send(8'h00, 1'b1, s); send(8'h05, 1'b1, s);
    send(8'h77, 1'b0, s);
    chk(s == 1'b1, "R5 unlatched write acked", s, 1);
    rdsr(st);
    chk(st == 8'h00, "R5 no cycle without latch", st, 0);
    read_at(5, d);
    chk(d == model[5], "R5 memory unchanged", d, model[5]);

    for (int p = 0; p < NB / 16; p++) begin
      wren();
      cmd(8'h6C, 1'b1, s);
      send(8'h00, 1'b1, s);
      send(8'(p * 16), 1'b1, s);
      for (int j = 0; j < 16; j++) begin
        send(pat(p * 16 + j), j != 15, s);
        chk(s == 1'b1, "R5 data ack", s, 1);
        model[p * 16 + j] = pat(p * 16 + j);
      end
      cmd(8'h03, 1'b1, s);
      chk(s == 1'b0, "R10 busy refuses read", s, 0);
      rdsr(st);
      chk(st == 8'h03, "R6 status during cycle", st, 3);
      wait_idle();
      rdsr(st);
      chk(st == 8'h00, "R9 latch clear after cycle", st, 0);
    end

    cmd(8'h03, 1'b1, s);
    send(8'h00, 1'b1, s); send(8'h00, 1'b1, s);
    for (int i = 0; i < NB + 2; i++) begin
      get(i != NB + 1, d, s);
      chk(d == model[i % NB] && s, "R2 sequential read", d, model[i % NB]);
    end
    cmd(8'h06, 1'b1, s);
    get(1'b0, d, s2);
    chk(d == model[2], "R3 current address read", d, model[2]);

    wren();
    cmd(8'h6C, 1'b1, s);
    send(8'h00, 1'b1, s); send(8'h1E, 1'b1, s);
    send(8'hA1, 1'b1, s); send(8'hA2, 1'b1, s); send(8'hA3, 1'b0, s);
    model[8'h1E] = 8'hA1; model[8'h1F] = 8'hA2; model[8'h10] = 8'hA3;
    wait_idle();
    cmd(8'h03, 1'b1, s);
    send(8'h00, 1'b1, s); send(8'h10, 1'b1, s);
    for (int i = 0; i < 16; i++) begin
      get(i != 15, d, s);
      chk(d == model[16 + i], "R5 page wrap", d, model[16 + i]);
    end

    for (int lvl = 0; lvl < 4; lvl++) begin
      wren();
      cmd(8'h6E, 1'b1, s);
      send(8'(lvl << 2), 1'b0, s);
      wait_idle();
      rdsr(st);
      chk(st == 8'(lvl << 2), "R7 level in status", st, lvl << 2);
      for (int q = 0; q < 4; q++) begin
        int a;
        bit prot;
        a = q * 32 + 5 + lvl;
        prot = (lvl == 3) || (lvl == 2 && q >= 2) || (lvl == 1 && q == 3);
        write_one(a, 8'(8'h40 + lvl * 4 + q), s);
        if (!prot) model[a] = 8'(8'h40 + lvl * 4 + q);
        read_at(a, d);
        chk(d == model[a], "R7 protection", d, model[a]);
      end
    end
    wren();
    cmd(8'h6E, 1'b1, s);
    send(8'h00, 1'b0, s);
    wait_idle();

    wren();
    cmd(8'h67, 1'b0, s);
    chk(s == 1'b1, "R8 fill acked", s, 1);
    wait_idle();
    cmd(8'h03, 1'b1, s);
    send(8'h00, 1'b1, s); send(8'h00, 1'b1, s);
    for (int i = 0; i < NB; i++) begin
      get(i != NB - 1, d, s);
      chk(d == 8'hFF, "R8 fill value", d, 8'hFF);
    end
    rdsr(st);
    chk(st == 8'h00, "R9 latch clear after fill", st, 0);

    get(1'b0, d, s);
    chk(s == 1'b0 && last_sv == 1'b1, "R11 stray read slot nacked", s, 0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule